// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 peripheral interrupt sources onto one parent interrupt line. A small register file on a simple 32-bit register bus holds a status vector and a mask vector. The parent line is high whenever any status bit is set and not masked. Software reads the status register to find which sources are pending. It handles them and then, in the latched build, acknowledges each source by writing a one to its clear bit.

The `LATCHED` parameter picks one of two builds at elaboration. In the latched build, each rising edge of a source sets a sticky status bit. A software-set register can also force status bits, and a write-one-to-clear register removes them. In the level build, the status register is the registered copy of the input levels. That build has no set register and no clear register, and its register offsets are packed more tightly. In both builds the mask is changed only through two write-one registers, one that sets mask bits and one that clears them, and it is read back through a mask-status register.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask-status register reads 0xFFFFFFFF (every source disabled), the status register reads 0, and `irq_o` is low.
- R2: A write to the mask-set register sets the mask bits written as 1, and a write to the mask-clear register clears them. Bits written as 0 keep their value. Writing 0xFFFFFFFF to mask-set masks every source.
- R3: `irq_o` is registered. One clock after the status and mask registers change, it equals the OR of (status AND NOT mask).
- R4: In the latched build, a 0-to-1 change of a source (the current sample is 1 and the previous clock's sample was 0) sets its status bit one clock later. The bit stays set after the source falls.
- R5: In the latched build, writing 1s to the clear register (offset 0x08) clears those status bits. Writing 0xFFFFFFFF clears all of them.
- R6: In the latched build, a rising edge in the same cycle as a clear write to the same bit wins, so the bit stays set.
- R7: Masking does not stop capture. A masked source still sets its status bit and raises `irq_o` once it is unmasked.
- R8: In the level build, the status register equals the previous clock's source levels and holds no history. Offset 0x08 is the mask-set register, not a clear register.
- R9: Reads of unmapped offsets return 0, and writes to them change no state. The write-only registers also read as 0.
- R10: In the latched build, writing 1s to the software-set register (offset 0x04) sets those status bits.
- R11: Byte offsets in the latched build: status 0x00, set 0x04, clear 0x08, mask status 0x0C, mask set 0x10, mask clear 0x14. In the level build: status 0x00, mask status 0x04, mask set 0x08, mask clear 0x0C. Read data is registered and appears one clock after the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, valid the clock after a read, 0 otherwise |
| irq_o | output | 1 | Parent interrupt, high while an unmasked bit is pending |

## Verification
The bench goes after a rising edge that arrives in the same cycle as its own clear write. A design that gives the clear priority would drop that interrupt. It pulses a masked source and later unmasks it. A design that gates capture with the mask would then stay silent. In the level build it writes ones to offset 0x08 and to the latched build's mask-clear offset. A design that kept the latched map would clear status or unmask sources there instead of masking everything. It also confirms that a latched bit survives its source falling, and that unmapped and write-only offsets read zero and leave the mask untouched.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [2:0] {
    RID_NONE,
    RID_STAT,
    RID_SET,
    RID_CLR,
    RID_MSTAT,
    RID_MSET,
    RID_MCLR
  } reg_id_e;

  // Byte offset to register, per build; offsets matter to software (R11)
  function automatic reg_id_e map_offset(input bit latched, input logic [7:0] off);
    reg_id_e r;
    r = RID_NONE;
    if (latched) begin
      case (off)
        8'h00: r = RID_STAT;
        8'h04: r = RID_SET;
        8'h08: r = RID_CLR;
        8'h0C: r = RID_MSTAT;
        8'h10: r = RID_MSET;
        8'h14: r = RID_MCLR;
        default: r = RID_NONE;
      endcase
    end else begin
      case (off)
        8'h00: r = RID_STAT;
        8'h04: r = RID_MSTAT;
        8'h08: r = RID_MSET;
        8'h0C: r = RID_MCLR;
        default: r = RID_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
  import irqagg_pkg::*;
#(
  parameter bit LATCHED = 1'b1,
  parameter int ADDR_W  = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           rd_id,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_mset,
  output logic              wr_mclr
);
  localparam int LOW_W = (ADDR_W < 8) ? ADDR_W : 8;

  logic [7:0] low_off;
  logic       hi_zero;
  reg_id_e    hit;

  always_comb begin
    low_off = '0;
    low_off[LOW_W-1:0] = addr[LOW_W-1:0];
    hi_zero = ((addr >> LOW_W) == '0);
    hit     = hi_zero ? map_offset(LATCHED, low_off) : RID_NONE;
  end

  assign rd_id   = (sel && !we) ? hit : RID_NONE;
  assign wr_set  = sel && we && (hit == RID_SET);
  assign wr_clr  = sel && we && (hit == RID_CLR);
  assign wr_mset = sel && we && (hit == RID_MSET);
  assign wr_mclr = sel && we && (hit == RID_MCLR);
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
  parameter int NSRC    = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] set_v,
  input  logic [NSRC-1:0] clr_v,
  output logic [NSRC-1:0] status_q
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] latch_nxt;
  logic [NSRC-1:0] status_nxt;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  assign rise = src_i & ~src_q;
  // Edge and software set are ORed after the clear, so they win over it
  assign latch_nxt  = (status_q & ~clr_v) | set_v | rise;
  assign status_nxt = LATCHED ? latch_nxt : src_i;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_nxt;
  end
endmodule

// File: rtl/irqagg_mask.sv
module irqagg_mask #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] mset_v,
  input  logic [NSRC-1:0] mclr_v,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q | mset_v) & ~mclr_v;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_o
);
  reg_id_e         rd_id;
  logic            wr_set, wr_clr, wr_mset, wr_mclr;
  logic [NSRC-1:0] set_v, clr_v, mset_v, mclr_v;
  logic [NSRC-1:0] status_q, mask_q;
  logic [NSRC-1:0] rd_val;

  irqagg_regdec #(.LATCHED(LATCHED), .ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .rd_id(rd_id), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_mset(wr_mset), .wr_mclr(wr_mclr)
  );

  assign set_v  = wr_set  ? bus_wdata : '0;
  assign clr_v  = wr_clr  ? bus_wdata : '0;
  assign mset_v = wr_mset ? bus_wdata : '0;
  assign mclr_v = wr_mclr ? bus_wdata : '0;

  irqagg_status #(.NSRC(NSRC), .LATCHED(LATCHED)) u_stat (
    .clk(clk), .rst(rst), .src_i(src_i),
    .set_v(set_v), .clr_v(clr_v), .status_q(status_q)
  );

  irqagg_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .mset_v(mset_v), .mclr_v(mclr_v), .mask_q(mask_q)
  );

  always_comb begin
    case (rd_id)
      RID_STAT:  rd_val = status_q;
      RID_MSTAT: rd_val = mask_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_val;
      irq_o     <= |(status_q & ~mask_q);
    end
  end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int NSRC    = 32,
  parameter bit LATCHED = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] clr_v,
  input logic [NSRC-1:0] mset_v,
  input logic [NSRC-1:0] mclr_v,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic            irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && !irq_o));

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(mset_v)) == $past(mset_v)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(mclr_v)) == '0));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(mset_v | mclr_v)) == '0));

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(status_q) & ~$past(mask_q))));

  generate
    if (LATCHED) begin : g_latched
      logic [NSRC-1:0] prev_src;
      always_ff @(posedge clk) begin
        if (rst) prev_src <= '0;
        else     prev_src <= src_i;
      end

      // R4
      sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ($past(status_q) & ~$past(clr_v)))
                  == ($past(status_q) & ~$past(clr_v))));

      // R6
      edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(src_i & ~prev_src)) == $past(src_i & ~prev_src)));
    end else begin : g_level
      // R8
      level_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_q == $past(src_i)));

      // R8
      no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_v == '0);
    end
  endgenerate
endmodule

bind irq_aggregator irqagg_chk #(.NSRC(NSRC), .LATCHED(LATCHED)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .clr_v(clr_v),
  .mset_v(mset_v), .mclr_v(mclr_v),
  .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          checks = 0, failures = 0, cycles = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_aggregator #(.NSRC(32), .ADDR_W(8), .LATCHED(1'b1)) dut (
    .clk(clk), .rst(rst), .src_i(src_a), .bus_sel(sel_a), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_o(irq_a));

  irq_aggregator #(.NSRC(32), .ADDR_W(8), .LATCHED(1'b0)) dut_lvl (
    .clk(clk), .rst(rst), .src_i(src_b), .bus_sel(sel_b), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_o(irq_b));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_a = !lvl; sel_b = lvl; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_a = !lvl; sel_b = lvl; we = 1'b0; addr = a;
    @(negedge clk);
    d = lvl ? rdata_b : rdata_a;
    sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic t_reset();
    rd(0, 8'h0C, rv); check("R1 mask after reset", rv, 32'hFFFF_FFFF);
    rd(0, 8'h00, rv); check("R1 status after reset", rv, 32'h0);
    check("R1 irq after reset", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_mask();
    wr(0, 8'h14, 32'h0000_00F0);
    rd(0, 8'h0C, rv); check("R2 mask clear", rv, 32'hFFFF_FF0F);
    wr(0, 8'h10, 32'h0000_0010);
    rd(0, 8'h0C, rv); check("R2 mask set", rv, 32'hFFFF_FF1F);
    wr(0, 8'h14, 32'h0);
    rd(0, 8'h0C, rv); check("R2 zero write keeps mask", rv, 32'hFFFF_FF1F);
    wr(0, 8'h10, 32'hFFFF_FFFF);
    rd(0, 8'h0C, rv); check("R2 all-ones mask set", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_latch();
    wr(0, 8'h14, 32'h0000_0020);
    @(negedge clk); src_a[5] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 irq after edge", {31'b0, irq_a}, 32'h1);
    src_a[5] = 1'b0;
    repeat (3) @(negedge clk);
    rd(0, 8'h00, rv); check("R4 sticky after fall", rv, 32'h0000_0020);
    check("R4 irq held", {31'b0, irq_a}, 32'h1);
    wr(0, 8'h08, 32'h0000_0020);
    @(negedge clk);
    check("R5 irq drops after clear", {31'b0, irq_a}, 32'h0);
    rd(0, 8'h00, rv); check("R5 status cleared", rv, 32'h0);
    @(negedge clk); src_a[3:0] = 4'hF;
    @(negedge clk); src_a[3:0] = 4'h0;
    @(negedge clk);
    rd(0, 8'h00, rv); check("R4 multi latch", rv, 32'h0000_000F);
    wr(0, 8'h08, 32'hFFFF_FFFF);
    rd(0, 8'h00, rv); check("R5 all-ones clear", rv, 32'h0);
    wr(0, 8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    @(negedge clk);
    src_a[2] = 1'b1;
    sel_a = 1'b1; we = 1'b1; addr = 8'h08; wdata = 32'h0000_0004;
    @(negedge clk);
    sel_a = 1'b0; we = 1'b0;
    rd(0, 8'h00, rv); check("R6 edge beats clear", rv, 32'h0000_0004);
    wr(0, 8'h08, 32'h0000_0004);
    rd(0, 8'h00, rv); check("R6 later clear works", rv, 32'h0);
    src_a[2] = 1'b0;
  endtask

  task automatic t_masked();
    @(negedge clk); src_a[9] = 1'b1;
    @(negedge clk); src_a[9] = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 masked no irq", {31'b0, irq_a}, 32'h0);
    rd(0, 8'h00, rv); check("R7 masked still latched", rv, 32'h0000_0200);
    wr(0, 8'h14, 32'h0000_0200);
    @(negedge clk);
    check("R7 irq on unmask", {31'b0, irq_a}, 32'h1);
    wr(0, 8'h10, 32'h0000_0200);
    @(negedge clk);
    check("R3 irq off on remask", {31'b0, irq_a}, 32'h0);
    wr(0, 8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_swset();
    wr(0, 8'h04, 32'h8000_0000);
    rd(0, 8'h00, rv); check("R10 software set", rv, 32'h8000_0000);
    rd(0, 8'h04, rv); check("R9 set reg reads zero", rv, 32'h0);
    wr(0, 8'h08, 32'h8000_0000);
    rd(0, 8'h00, rv); check("R10 cleared", rv, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(0, 8'h18, 32'hFFFF_FFFF);
    wr(0, 8'h14 | 8'h80, 32'hFFFF_FFFF);
    rd(0, 8'h18, rv); check("R9 unmapped read", rv, 32'h0);
    rd(0, 8'h0C, rv); check("R9 mask untouched", rv, 32'hFFFF_FFFF);
    rd(0, 8'h00, rv); check("R9 status untouched", rv, 32'h0);
  endtask

  task automatic t_level();
    rd(1, 8'h04, rv); check("R11 level mask offset", rv, 32'hFFFF_FFFF);
    @(negedge clk); src_b = 32'h0000_00A5;
    repeat (2) @(negedge clk);
    rd(1, 8'h00, rv); check("R8 level status", rv, 32'h0000_00A5);
    wr(1, 8'h0C, 32'h0000_0001);
    @(negedge clk);
    check("R8 level irq", {31'b0, irq_b}, 32'h1);
    wr(1, 8'h08, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 0x08 masks all", {31'b0, irq_b}, 32'h0);
    rd(1, 8'h00, rv); check("R8 0x08 is no clear", rv, 32'h0000_00A5);
    wr(1, 8'h14, 32'h0000_00FF);
    rd(1, 8'h04, rv); check("R9 level unmapped write", rv, 32'hFFFF_FFFF);
    rd(1, 8'h14, rv); check("R9 level unmapped read", rv, 32'h0);
    @(negedge clk); src_b = 32'h0;
    repeat (2) @(negedge clk);
    rd(1, 8'h00, rv); check("R8 level no history", rv, 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog got=%0d exp<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_latch();
    t_collide();
    t_masked();
    t_swset();
    t_unmapped();
    t_level();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule